// File: doc/BRIEF.md
# I2C Controller Interrupt Register Set

This block holds the interrupt registers of an I2C controller. Ten event pulses from the controller set sticky status bits. Software clears status bits by writing ones to the status register. A hidden enable mask is changed only through two write-only registers: one sets mask bits and the other clears them. The mask can be read back at its own offset. A single registered interrupt line rises when any status bit is both set and enabled. A second registered line flags that an error-class event is pending, whatever the mask holds.

The register port is a plain single-cycle write strobe with a combinational read of the addressed register. The event sources themselves are outside the block.

Bit layout, shared by status, mask, enable and disable:

| Bit | Event |
|-----|-------|
| 0 | completion |
| 1 | data |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | RX overflow |
| 6 | TX overflow |
| 7 | RX underflow |
| 8 | reserved |
| 9 | arbitration lost |

Top module: `i2c_irq_regs`

## Requirements
- R1: Reset clears every status bit and every mask bit, and drives irq_o and err_o low.
- R2: An event pulse on ev_i[i] sets status bit i at the next clock edge. Status reads at offset 0x10, in the layout given above.
- R3: A write to offset 0x10 clears the status bits written as 1 and leaves the bits written as 0 unchanged. Writing back a value read from status therefore clears exactly the bits that were set.
- R4: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A 1 written to a bit of the enable register (offset 0x24) sets that mask bit. A 0 leaves the mask bit unchanged. The mask reads at offset 0x20.
- R6: A 1 written to a bit of the disable register (offset 0x28) clears that mask bit. A 0 leaves the mask bit unchanged.
- R7: Bit 8 is reserved. No event or enable write sets it, and it reads as 0 in both status and mask.
- R8: irq_o is registered. It is high one cycle after a cycle in which some status bit and the matching mask bit are both 1, and low otherwise.
- R9: err_o is registered. It is high one cycle after a cycle in which any error-class status bit (2, 5, 6, 7 or 9) is set, regardless of the mask. Bits 0, 1, 3 and 4 never raise it.
- R10: The enable and disable offsets read as 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NSRC (10) | One-cycle event pulses, one per status bit |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wdata | input | NSRC (10) | Write data |
| bus_rdata | output | DW (32) | Read data of the addressed register, zero-extended |
| irq_o | output | 1 | Registered interrupt: some status bit is set and enabled |
| err_o | output | 1 | Registered flag: an error-class status bit is set |

## Verification
The hardest case to reach is a clear that lands in the very cycle an event pulse arrives on the same bit. A normal register write cannot be timed against an event by software, so the stimulus table drives both in one vector and then reads status back to show the bit survived. The one-cycle lag of irq_o behind status is also easy to miss. A directed test samples irq_o between the edge that sets status and the next edge, where it must still be low.

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NSRC = 10,
  parameter logic [NSRC-1:0] VALID = 10'h2FF,
  parameter logic [NSRC-1:0] ERR = 10'h2E4,
  parameter logic [AW-1:0] A_STAT = 8'h10,
  parameter logic [AW-1:0] A_MASK = 8'h20,
  parameter logic [AW-1:0] A_EN = 8'h24,
  parameter logic [AW-1:0] A_DIS = 8'h28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            err_o
);

  logic [NSRC-1:0] status_q, mask_q;
  logic [NSRC-1:0] clr_bits, set_m, clr_m;

  assign clr_bits = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;
  assign set_m    = (bus_wr && bus_addr == A_EN)   ? bus_wdata : '0;
  assign clr_m    = (bus_wr && bus_addr == A_DIS)  ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      status_q <= ((status_q & ~clr_bits) | ev_i) & VALID;
      mask_q   <= ((mask_q | set_m) & ~clr_m) & VALID;
      irq_o    <= |(status_q & mask_q);
      err_o    <= |(status_q & ERR);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)      bus_rdata[NSRC-1:0] = status_q;
    else if (bus_addr == A_MASK) bus_rdata[NSRC-1:0] = mask_q;
  end

endmodule

// File: rtl/i2c_irq_regs_chk.sv
module i2c_irq_regs_chk #(
  parameter int AW = 8,
  parameter int NSRC = 10,
  parameter logic [NSRC-1:0] VALID = 10'h2FF,
  parameter logic [NSRC-1:0] ERR = 10'h2E4,
  parameter logic [AW-1:0] A_STAT = 8'h10,
  parameter logic [AW-1:0] A_EN = 8'h24,
  parameter logic [AW-1:0] A_DIS = 8'h28
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ev_i,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic            irq_o,
  input logic            err_o
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~VALID) == '0) && ((mask_q & ~VALID) == '0)); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(status_q & mask_q))); // R8

  AST_ERR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_o == $past(|(status_q & ERR))); // R9

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (VALID[i]) begin : g_v
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[i] |=> status_q[i]); // R4
      AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && bus_wdata[i] && !ev_i[i]) |=> !status_q[i]); // R3
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[i] && !(bus_wr && bus_addr == A_STAT && bus_wdata[i])) |=> $stable(status_q[i])); // R3
      AST_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN && bus_wdata[i]) |=> mask_q[i]); // R5
      AST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS && bus_wdata[i]) |=> !mask_q[i]); // R6
    end
  end

endmodule

bind i2c_irq_regs i2c_irq_regs_chk #(
  .AW(AW), .NSRC(NSRC), .VALID(VALID), .ERR(ERR),
  .A_STAT(A_STAT), .A_EN(A_EN), .A_DIS(A_DIS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
  .mask_q(mask_q), .irq_o(irq_o), .err_o(err_o)
);

// File: tb/test_i2c_irq_regs.sv
module test_i2c_irq_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ev_i = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic [9:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_irq_regs i_i2c_irq_regs (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [9:0] ev;
    logic       wr;
    logic [7:0] addr;
    logic [9:0] wd;
    logic [9:0] st;
    logic [9:0] mk;
    logic       irq;
    logic       err;
    int         req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{10'h001, 1'b0, 8'h00, 10'h000, 10'h001, 10'h000, 1'b0, 1'b0, 2},  // R2 completion event
    '{10'h000, 1'b1, 8'h24, 10'h001, 10'h001, 10'h001, 1'b1, 1'b0, 5},  // R5 enable bit 0
    '{10'h004, 1'b0, 8'h00, 10'h000, 10'h005, 10'h001, 1'b1, 1'b1, 9},  // R9 NACK raises err
    '{10'h000, 1'b1, 8'h10, 10'h001, 10'h004, 10'h001, 1'b0, 1'b1, 3},  // R3 clear bit 0
    '{10'h000, 1'b1, 8'h24, 10'h3FF, 10'h004, 10'h2FF, 1'b1, 1'b1, 5},  // R5 enable all
    '{10'h000, 1'b1, 8'h28, 10'h004, 10'h004, 10'h2FB, 1'b0, 1'b1, 6},  // R6 disable bit 2
    '{10'h100, 1'b0, 8'h00, 10'h000, 10'h004, 10'h2FB, 1'b0, 1'b1, 7},  // R7 reserved event
    '{10'h200, 1'b0, 8'h00, 10'h000, 10'h204, 10'h2FB, 1'b1, 1'b1, 2},  // R2 arbitration lost
    '{10'h000, 1'b1, 8'h10, 10'h204, 10'h000, 10'h2FB, 1'b0, 1'b0, 3},  // R3 write back
    '{10'h020, 1'b1, 8'h10, 10'h020, 10'h020, 10'h2FB, 1'b1, 1'b1, 4},  // R4 event beats clear
    '{10'h000, 1'b1, 8'h14, 10'h3FF, 10'h020, 10'h2FB, 1'b1, 1'b1, 10}, // R10 other offset
    '{10'h000, 1'b1, 8'h10, 10'h3FF, 10'h000, 10'h2FB, 1'b0, 1'b0, 3},  // R3 clear all
    '{10'h002, 1'b0, 8'h00, 10'h000, 10'h002, 10'h2FB, 1'b1, 1'b0, 9},  // R9 data not error
    '{10'h000, 1'b1, 8'h28, 10'h3FF, 10'h002, 10'h000, 1'b0, 1'b0, 6},  // R6 disable all
    '{10'h3FF, 1'b0, 8'h00, 10'h000, 10'h2FF, 10'h000, 1'b0, 1'b1, 7},  // R7 all events
    '{10'h000, 1'b1, 8'h24, 10'h000, 10'h2FF, 10'h000, 1'b0, 1'b1, 5},  // R5 zeros no effect
    '{10'h000, 1'b1, 8'h10, 10'h000, 10'h2FF, 10'h000, 1'b0, 1'b1, 3}   // R3 zeros no effect
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    ev_i = v.ev; bus_wr = v.wr; bus_addr = v.addr; bus_wdata = v.wd;
    @(negedge clk);
    ev_i = '0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h10;
    #1 check(bus_rdata, {22'd0, v.st}, v.req, "status");
    @(negedge clk);
    check({31'd0, irq_o}, {31'd0, v.irq}, v.req, "irq");
    check({31'd0, err_o}, {31'd0, v.err}, v.req, "err");
    bus_addr = 8'h20;
    #1 check(bus_rdata, {22'd0, v.mk}, v.req, "mask");
  endtask

  task automatic wr(input logic [7:0] a, input logic [9:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_addr = 8'h10;
    #1 check(bus_rdata, 32'h0, 1, "reset status");
    bus_addr = 8'h20;
    #1 check(bus_rdata, 32'h0, 1, "reset mask");
    check({31'd0, irq_o}, 32'h0, 1, "reset irq");
    check({31'd0, err_o}, 32'h0, 1, "reset err");

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R10 enable/disable offsets read zero
    wr(8'h24, 10'h2FF);
    bus_addr = 8'h24;
    #1 check(bus_rdata, 32'h0, 10, "enable reads zero");
    bus_addr = 8'h28;
    #1 check(bus_rdata, 32'h0, 10, "disable reads zero");

    // R8 irq lags status by one edge
    wr(8'h28, 10'h3FF);
    wr(8'h10, 10'h3FF);
    wr(8'h24, 10'h002);
    @(negedge clk);
    check({31'd0, irq_o}, 32'h0, 8, "irq idle");
    ev_i = 10'h002;
    @(posedge clk);
    #1 ev_i = '0;
    bus_addr = 8'h10;
    #1 check(bus_rdata, 32'h2, 8, "status set");
    check({31'd0, irq_o}, 32'h0, 8, "irq not yet");
    @(posedge clk);
    #1 check({31'd0, irq_o}, 32'h1, 8, "irq one edge later");
    check({31'd0, err_o}, 32'h0, 9, "data event no err");

    // R1 reset mid-run
    ev_i = 10'h004;
    @(negedge clk);
    ev_i = '0;
    rst_n = 1'b0;
    #1 check(bus_rdata, 32'h0, 1, "status after reset");
    check({31'd0, irq_o}, 32'h0, 1, "irq after reset");
    check({31'd0, err_o}, 32'h0, 1, "err after reset");
    bus_addr = 8'h20;
    #1 check(bus_rdata, 32'h0, 1, "mask after reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule